// File: doc/BRIEF.md
# Saturating 16-bit Multiply-Accumulate Unit

This unit multiplies two signed 16-bit operands each cycle its valid strobe is high and adds the signed 32-bit product to an accumulator that is kept as two 32-bit words, a high word and a low word. The product is always added to the low word. What happens after that depends on a mode input sampled with the operation.

In saturating mode the low word behaves as a 32-bit signed accumulator that clamps at its most positive or most negative value. Any clamp also sets bit 0 of the high word, and that bit stays set until the accumulator is cleared or loaded. In wide mode the high word takes the sign of the product and the carry out of the low-word addition. Only its bits 9:0 are kept, and bit 9 is copied into every bit above it, so the high and low words together hold a 42-bit signed total.

A synchronous clear zeroes both words. A synchronous load writes both words from dedicated inputs, which lets a caller preload a running total or test a boundary. When valid, clear and load are all low, the accumulator holds its value.

Top module: `mac_unit`

## Requirements
- R1: Both operands are read as two's-complement 16-bit values. Their product is a signed 32-bit value.
- R2: An accepted operation (op_valid high, clear and load low) writes the low 32 bits of product plus old low word into the low word on the next rising clock edge, unless R4 clamps it.
- R3: In saturating mode (sat_mode=1) an overflow occurs when the product and the old low word have equal bit 31 and the sum's bit 31 differs from the product's. With no overflow the high word is left unchanged.
- R4: On a saturating-mode overflow the low word becomes 0x80000000 when the product is negative and 0x7FFFFFFF otherwise, and bit 0 of the high word is set.
- R5: Once set, bit 0 of the high word stays set through later saturating-mode operations that do not overflow.
- R6: In wide mode (sat_mode=0) the new high word is the old high word plus 0xFFFFFFFF when the product is negative (zero otherwise) plus the unsigned carry out of the low-word addition.
- R7: In wide mode the result of R6 keeps its bits 9:0 and bits 31:10 are copies of bit 9.
- R8: acc_clear zeroes both words on the next edge. It takes priority over load and over an operation.
- R9: acc_load writes load_hi and load_lo into the words on the next edge. It takes priority over an operation.
- R10: With op_valid, acc_clear and acc_load all low, both words hold their values whatever the operand and mode inputs do.
- R11: Synchronous active-high reset zeroes both words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept one multiply-accumulate this cycle |
| op_a | input | 16 | Signed operand A |
| op_b | input | 16 | Signed operand B |
| sat_mode | input | 1 | 1: saturating 32-bit mode, 0: wide 42-bit mode |
| acc_clear | input | 1 | Zero both accumulator words |
| acc_load | input | 1 | Load both words from load_hi/load_lo |
| load_hi | input | 32 | Value loaded into the high word |
| load_lo | input | 32 | Value loaded into the low word |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |

## Verification
Directed cases drive a preloaded low word across the positive and the negative 32-bit limit in saturating mode. They show that the clamp direction follows the sign of the product, and that the sticky bit survives a later subtraction that does not overflow. In wide mode, a carry out of the low word raises the high word from 0x1FF to 0x200. This tells the bit-9 sign extension apart from plain 32-bit addition, and a negative product with no carry shows the added all-ones term. A fixed-seed random stream mixes both modes, full-range operands (including -32768 times -32768) and occasional loads and clears, and compares every cycle against a bench model. Simultaneous clear, load and valid requests check the priority order, and idle cycles with changing operands check the hold behaviour.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int MAC_OP_W     = 16;
    localparam int MAC_WIDE_MSB = 9;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_MAC   = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } mac_act_e;

    function automatic mac_act_e pick_action(input logic clr, input logic ld, input logic vld);
        if (clr)      return ACT_CLEAR;
        else if (ld)  return ACT_LOAD;
        else if (vld) return ACT_MAC;
        else          return ACT_HOLD;
    endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W = 16,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [PROD_W-1:0] prod
);
    logic signed [PROD_W-1:0] a_ext, b_ext;
    always_comb begin
        a_ext = PROD_W'($signed(a));
        b_ext = PROD_W'($signed(b));
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/mac_sat_path.sv
module mac_sat_path #(
    parameter int W = 32
) (
    input  logic [W-1:0] prod,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         ovf,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W-1:0] sum;
    logic         neg;
    always_comb begin
        sum = prod + lo;
        neg = prod[W-1];
        ovf = (prod[W-1] == lo[W-1]) && (sum[W-1] != prod[W-1]);
        if (ovf) begin
            nxt_lo = {neg, {(W-1){~neg}}};
            nxt_hi = hi | {{(W-1){1'b0}}, 1'b1};
        end else begin
            nxt_lo = sum;
            nxt_hi = hi;
        end
    end
endmodule

// File: rtl/mac_wide_path.sv
module mac_wide_path #(
    parameter int W        = 32,
    parameter int KEEP_MSB = 9,
    localparam int EXT_W   = W - KEEP_MSB - 1
) (
    input  logic [W-1:0] prod,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W:0]   lo_full;
    logic [W-1:0] hi_sum;
    always_comb begin
        lo_full = {1'b0, prod} + {1'b0, lo};
        nxt_lo  = lo_full[W-1:0];
        hi_sum  = hi + {W{prod[W-1]}} + {{(W-1){1'b0}}, lo_full[W]};
    end

    generate
        if (EXT_W > 0) begin : g_ext
            assign nxt_hi = {{EXT_W{hi_sum[KEEP_MSB]}}, hi_sum[KEEP_MSB:0]};
        end else begin : g_noext
            assign nxt_hi = hi_sum;
        end
    endgenerate
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int OP_W     = MAC_OP_W,
    parameter int WIDE_MSB = MAC_WIDE_MSB,
    localparam int ACC_W   = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             sat_mode,
    input  logic             acc_clear,
    input  logic             acc_load,
    input  logic [ACC_W-1:0] load_hi,
    input  logic [ACC_W-1:0] load_lo,
    output logic [ACC_W-1:0] acc_hi,
    output logic [ACC_W-1:0] acc_lo
);
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] sat_hi, sat_lo, wide_hi, wide_lo;
    logic             sat_ovf;
    mac_act_e         act;

    mac_mult #(.OP_W(OP_W)) u_mult (.a(op_a), .b(op_b), .prod(prod));

    mac_sat_path #(.W(ACC_W)) u_sat (
        .prod(prod), .lo(acc_lo), .hi(acc_hi),
        .ovf(sat_ovf), .nxt_hi(sat_hi), .nxt_lo(sat_lo)
    );

    mac_wide_path #(.W(ACC_W), .KEEP_MSB(WIDE_MSB)) u_wide (
        .prod(prod), .lo(acc_lo), .hi(acc_hi),
        .nxt_hi(wide_hi), .nxt_lo(wide_lo)
    );

    assign act = pick_action(acc_clear, acc_load, op_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: begin acc_hi <= '0;      acc_lo <= '0;      end
                ACT_LOAD:  begin acc_hi <= load_hi; acc_lo <= load_lo; end
                ACT_MAC: begin
                    if (sat_mode) begin acc_hi <= sat_hi;  acc_lo <= sat_lo;  end
                    else          begin acc_hi <= wide_hi; acc_lo <= wide_lo; end
                end
                default: ;
            endcase
        end
    end

    // R5: sticky bit is never dropped by a saturating operation
    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && sat_mode && !acc_clear && !acc_load && acc_hi[0]) |=> acc_hi[0]);

    // R4: a fresh sticky bit always comes with a clamped low word
    assert_sat_limit_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && sat_mode && !acc_clear && !acc_load && !acc_hi[0]) |=>
        (!acc_hi[0] || acc_lo == {1'b0, {(ACC_W-1){1'b1}}} || acc_lo == {1'b1, {(ACC_W-1){1'b0}}}));

    // R7: wide-mode high word is sign-extended above bit WIDE_MSB
    assert_wide_signext_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sat_mode && !acc_clear && !acc_load) |=>
        ((acc_hi[ACC_W-1:WIDE_MSB] == '0) || (acc_hi[ACC_W-1:WIDE_MSB] == '1)));

    // R8: clear wins over everything
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        acc_clear |=> (acc_hi == '0 && acc_lo == '0));

    // R9: load takes the given words
    assert_load_take_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_load && !acc_clear) |=> (acc_hi == $past(load_hi) && acc_lo == $past(load_lo)));

    // R10: idle cycles hold state
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !acc_clear && !acc_load) |=> ($stable(acc_hi) && $stable(acc_lo)));
endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, sat_mode, acc_clear, acc_load;
    logic [15:0] op_a, op_b;
    logic [31:0] load_hi, load_lo;
    logic [31:0] acc_hi, acc_lo;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_hi, exp_lo;

    always #4 clk = ~clk;   // 125 MHz

    mac_unit u_mac_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .sat_mode(sat_mode), .acc_clear(acc_clear), .acc_load(acc_load),
        .load_hi(load_hi), .load_lo(load_lo), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    // Reference model built from the requirements (R1..R7)
    function automatic logic [63:0] ref_mac(input logic [31:0] hi, input logic [31:0] lo,
                                            input logic [15:0] a, input logic [15:0] b,
                                            input logic sat);
        longint p64;
        logic [31:0] p, s, h;
        logic [32:0] full;
        p64  = longint'($signed(a)) * longint'($signed(b));
        p    = p64[31:0];
        full = {1'b0, p} + {1'b0, lo};
        s    = full[31:0];
        if (sat) begin
            if (p[31] == lo[31] && s[31] != p[31])
                return {hi | 32'h1, (p[31] ? 32'h8000_0000 : 32'h7FFF_FFFF)};
            return {hi, s};
        end
        h = hi + (p[31] ? 32'hFFFF_FFFF : 32'h0) + {31'b0, full[32]};
        return {{22{h[9]}}, h[9:0], s};
    endfunction

    task automatic check(input string tag, input logic [31:0] ehi, input logic [31:0] elo);
        n_tests++;
        if (acc_hi !== ehi || acc_lo !== elo) begin
            n_fail++;
            $display("FAIL %s: hi=%08h lo=%08h expected hi=%08h lo=%08h", tag, acc_hi, acc_lo, ehi, elo);
        end
    endtask

    task automatic idle_inputs();
        op_valid = 0; acc_clear = 0; acc_load = 0;
    endtask

    // all drives happen at a negedge; the result is sampled at the following negedge
    task automatic do_load(input logic [31:0] h, input logic [31:0] l);
        idle_inputs(); acc_load = 1; load_hi = h; load_lo = l;
        @(negedge clk); idle_inputs();
        exp_hi = h; exp_lo = l;
    endtask

    task automatic do_op(input logic [15:0] a, input logic [15:0] b, input logic sat, input string tag);
        logic [63:0] r;
        idle_inputs(); op_valid = 1; op_a = a; op_b = b; sat_mode = sat;
        r = ref_mac(exp_hi, exp_lo, a, b, sat);
        @(negedge clk); idle_inputs();
        exp_hi = r[63:32]; exp_lo = r[31:0];
        check(tag, exp_hi, exp_lo);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int unused;
        unused = $urandom(32'd2024);
        rst = 1; idle_inputs(); op_a = 0; op_b = 0; sat_mode = 0; load_hi = 0; load_lo = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R11 reset", 32'h0, 32'h0);
        exp_hi = 0; exp_lo = 0;

        // R1/R2 basic signed products
        do_op(16'd3, 16'hFFFB, 1'b1, "R1 3*-5");
        check("R1 value", 32'h0, 32'hFFFF_FFF1);
        do_op(16'h8000, 16'h8000, 1'b1, "R1 min*min");
        check("R2 value", 32'h0, 32'h3FFF_FFF1);

        // R4 positive overflow, then R5 sticky across a non-overflow
        do_load(32'h0, 32'h7FFF_FFF0);
        do_op(16'h7FFF, 16'h7FFF, 1'b1, "R4 pos ovf");
        check("R4 pos clamp", 32'h1, 32'h7FFF_FFFF);
        do_op(16'hFFFF, 16'h0001, 1'b1, "R5 sticky");
        check("R5 sticky hold", 32'h1, 32'h7FFF_FFFE);

        // R4 negative overflow
        do_load(32'h0, 32'h8000_0010);
        do_op(16'h8000, 16'h7FFF, 1'b1, "R4 neg ovf");
        check("R4 neg clamp", 32'h1, 32'h8000_0000);
        do_op(16'd2, 16'd2, 1'b1, "R5 sticky2");
        check("R5 sticky after add", 32'h1, 32'h8000_0004);

        // R3 mixed signs never overflow; high word untouched
        do_load(32'h0000_0ABC, 32'h7FFF_FFFF);
        do_op(16'h8000, 16'h7FFF, 1'b1, "R3 no ovf");
        check("R3 hi kept", 32'h0000_0ABC, 32'h4000_7FFF);

        // R6/R7 wide mode: carry pushes hi 0x1FF -> 0x200 then sign-extends
        do_load(32'h0000_01FF, 32'hFFFF_FFFF);
        do_op(16'd1, 16'd1, 1'b0, "R6 carry");
        check("R7 signext", 32'hFFFF_FE00, 32'h0);
        do_load(32'h0, 32'h0);
        do_op(16'hFFFF, 16'd1, 1'b0, "R6 neg prod");
        check("R6 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R8 clear beats load and valid
        idle_inputs(); acc_clear = 1; acc_load = 1; op_valid = 1; load_hi = 32'h1234; load_lo = 32'h5678;
        @(negedge clk); idle_inputs();
        exp_hi = 0; exp_lo = 0;
        check("R8 clear priority", 32'h0, 32'h0);

        // R9 load beats valid
        acc_load = 1; op_valid = 1; op_a = 16'd7; op_b = 16'd7; load_hi = 32'h55; load_lo = 32'hAA;
        @(negedge clk); idle_inputs();
        exp_hi = 32'h55; exp_lo = 32'hAA;
        check("R9 load priority", 32'h55, 32'hAA);

        // R10 idle holds with wiggling operands
        for (int i = 0; i < 4; i++) begin
            op_a = 16'($urandom); op_b = 16'($urandom); sat_mode = 1'($urandom);
            @(negedge clk);
            check("R10 hold", exp_hi, exp_lo);
        end

        // Random stream mixing modes, with occasional loads and clears
        for (int i = 0; i < 600; i++) begin
            int sel;
            sel = int'($urandom_range(0, 19));
            if (sel == 0) begin
                idle_inputs(); acc_clear = 1;
                @(negedge clk); idle_inputs();
                exp_hi = 0; exp_lo = 0;
                check("R8 random clear", exp_hi, exp_lo);
            end else if (sel == 1) begin
                do_load($urandom, $urandom);
                check("R9 random load", exp_hi, exp_lo);
            end else if (sel == 2) begin
                do_op(16'h8000, 16'h8000, 1'($urandom), "R1 random extreme");
            end else begin
                do_op(16'($urandom), 16'($urandom), 1'($urandom), "R2 random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule